// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target side of a three-wire serial programming link. While the programming-enable pin is held high, an external programmer clocks instructions in on `mosi` with `sck` and reads results back on `miso`. Through these instructions the on-chip code memory can be erased, written one byte or one page at a time, and read back. The serial clock is oversampled by the system clock, so `sck` must run at less than one sixteenth of `clk`.

Every instruction is four bytes, sent MSB first: an opcode, the high address byte, the low address byte, and a data byte. The one exception is the page write. It is an opcode and a page byte, followed by 256 data bytes. Nothing except the unlock instruction has any effect until that instruction has been seen. The unlock is lost whenever the enable pin drops.

The memory behaves like flash. An erase sets every location to 8'hFF. A write can only clear bits, so a location must be erased before it can be rewritten freely. Each write starts a self-timed busy period. While it lasts, a read of the location just written returns that byte with its MSB inverted, which the programmer can use as a completion flag.

Top module: `isp_target`

## Requirements
- R1: While `progEn` is low, `miso` is 0 and `sck` edges have no effect.
- R2: Until the unlock instruction (opcode 8'hAC, second byte 8'h53) has completed, no erase or write takes effect and a read returns 0 on `miso`.
- R3: The erase instruction (opcode 8'hAC, second byte 8'h80) sets every location to 8'hFF.
- R4: A byte write stores the bitwise AND of the old content and the data byte. Bits can only change from 1 to 0 without an erase.
- R5: `mosi` is captured on rising `sck` edges detected in the `clk` domain, MSB first, eight bits per byte.
- R6: During the fourth byte of a read (opcode 8'h20), `miso` presents the addressed byte MSB first. Each bit changes after a falling `sck` edge. `miso` is 0 at every other time.
- R7: Each byte written (opcode 8'h40, or page data) starts a busy period of `WRITE_CYCLES` clocks. An erase keeps the block busy for one clock per location.
- R8: A byte write, erase or page write that arrives while the block is busy is dropped. Reads are still served.
- R9: While a write is busy, a read of the last address written returns that byte with bit 7 inverted. Reads of other addresses, and reads after the busy period, return the true value.
- R10: A page write (opcode 8'h50) takes the page number from its second byte. The 256 data bytes that follow are written to offsets 0 to 255 of that page.
- R11: When `progEn` goes low, the unlock state, the bit count and any partial instruction are cleared.
- R12: A four-byte instruction with any other opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progEn | input | 1 | Programming mode enable, active high |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |

## Verification
The in-RTL assertions check the following on every cycle:
- `miso` moves only after a detected falling edge or on leaving programming mode.
- `miso` and the unlock flag drop when `progEn` is low.
- No memory strobe fires while the block is locked.
- Erases and single-byte writes never start while busy.
- A write is always followed by busy.

Only the bench scenarios can show the memory contents that result from an instruction sequence. These include:
- the all-ones fill after an erase
- the bit-clearing rewrite
- the placement of page data
- the inverted MSB during polling
- instructions that are dropped because they arrived locked or busy

// File: rtl/isp_pkg.sv
package isp_pkg;
  // Single-cycle requests from the control to the datapath
  typedef struct packed {
    logic byteWr;    // write cmdData to cmdAddr (bits can only clear)
    logic eraseGo;   // start the all-ones sweep
    logic readLoad;  // capture memory[cmdAddr] into the output shifter
    logic readEnd;   // stop presenting read data
  } ispStrobes_t;
endpackage

// File: rtl/isp_flash_array.sv
module isp_flash_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              progWe,
  input  logic              eraseWe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // Flash-like cells: erase sets, programming can only clear bits
  always_ff @(posedge clk) begin
    if (eraseWe)     mem[wrAddr] <= 8'hFF;
    else if (progWe) mem[wrAddr] <= mem[wrAddr] & wrData;
  end

  assign rdData = mem[rdAddr];

  // R3/R4: the sweep and a byte program never share a cycle
  always_comb p_single_port_r3: assert (!(eraseWe && progWe));
endmodule

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 16000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEn,
  input  logic              sck,
  input  logic              mosi,
  input  ispStrobes_t       strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output logic              progOn,
  output logic              byteDone,
  output logic [7:0]        byteVal,
  output logic              busy,
  output logic              miso
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  // ---------------- synchronisers ----------------
  logic [1:0] progS;
  logic [2:0] sckS;
  logic [1:0] mosiS;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progS <= '0;
      sckS  <= '0;
      mosiS <= '0;
    end else begin
      progS <= {progS[0], progEn};
      sckS  <= {sckS[1:0], sck};
      mosiS <= {mosiS[0], mosi};
    end
  end

  assign progOn = progS[1];
  logic sckRise, sckFall;
  assign sckRise = progOn &  sckS[1] & ~sckS[2];
  assign sckFall = progOn & ~sckS[1] &  sckS[2];

  // ---------------- input shifter ----------------
  logic [6:0] shiftReg;
  logic [2:0] bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (!progOn) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (sckRise) begin
      shiftReg <= {shiftReg[5:0], mosiS[1]};
      bitCnt   <= bitCnt + 3'd1;
    end
  end
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign byteVal  = {shiftReg, mosiS[1]};

  // ---------------- busy timing and erase sweep ----------------
  logic [TW-1:0]     wrTimer;
  logic              sweeping;
  logic [ADDR_W-1:0] sweepAddr;
  logic [ADDR_W-1:0] lastAddr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTimer   <= '0;
      sweeping  <= 1'b0;
      sweepAddr <= '0;
      lastAddr  <= '0;
    end else begin
      if (strb.byteWr) begin
        wrTimer  <= TW'(WRITE_CYCLES);
        lastAddr <= cmdAddr;
      end else if (wrTimer != '0) begin
        wrTimer <= wrTimer - TW'(1);
      end
      if (strb.eraseGo) begin
        sweeping  <= 1'b1;
        sweepAddr <= '0;
      end else if (sweeping) begin
        sweepAddr <= sweepAddr + ADDR_W'(1);
        if (&sweepAddr) sweeping <= 1'b0;
      end
    end
  end

  logic writeBusy;
  assign writeBusy = (wrTimer != '0);
  assign busy      = writeBusy | sweeping;

  // ---------------- memory ----------------
  logic [7:0] rdData;
  isp_flash_array #(.ADDR_W(ADDR_W)) uArray (
    .clk    (clk),
    .progWe (strb.byteWr),
    .eraseWe(sweeping),
    .wrAddr (sweeping ? sweepAddr : cmdAddr),
    .wrData (cmdData),
    .rdAddr (cmdAddr),
    .rdData (rdData)
  );

  // ---------------- output shifter ----------------
  logic       pollHit;
  logic [7:0] outReg;
  logic       outActive;
  assign pollHit = writeBusy && (cmdAddr == lastAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg    <= '0;
      outActive <= 1'b0;
      miso      <= 1'b0;
    end else if (!progOn) begin
      outReg    <= '0;
      outActive <= 1'b0;
      miso      <= 1'b0;
    end else if (strb.readLoad) begin
      outReg    <= rdData ^ {pollHit, 7'b0};
      outActive <= 1'b1;
    end else if (strb.readEnd) begin
      outActive <= 1'b0;
    end else if (sckFall) begin
      miso   <= outActive & outReg[7];
      outReg <= {outReg[6:0], 1'b0};
    end
  end

  // R1: output quiet outside programming mode
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !progOn |=> !miso);
  // R6: output only moves after a falling serial edge or on leaving the mode
  p_miso_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (miso != $past(miso)) |-> ($past(sckFall) || !$past(progOn)));
  // R7: a write always opens a busy window
  p_busy_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWr |=> busy);
endmodule

// File: rtl/isp_control.sv
module isp_control
  import isp_pkg::*;
#(
  parameter int         ADDR_W     = 10,
  parameter logic [7:0] ENABLE_OP  = 8'hAC,
  parameter logic [7:0] ENABLE_KEY = 8'h53,
  parameter logic [7:0] ERASE_OP   = 8'hAC,
  parameter logic [7:0] ERASE_SUB  = 8'h80,
  parameter logic [7:0] WRITE_OP   = 8'h40,
  parameter logic [7:0] READ_OP    = 8'h20,
  parameter logic [7:0] PAGE_OP    = 8'h50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progOn,
  input  logic              byteDone,
  input  logic [7:0]        byteVal,
  input  logic              busy,
  output ispStrobes_t       strb,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData
);
  logic [1:0] byteIdx;
  logic [7:0] opReg, b1Reg, loReg, pageOff;
  logic       pageMode, pageOk, unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx  <= '0;
      opReg    <= '0;
      b1Reg    <= '0;
      loReg    <= '0;
      pageOff  <= '0;
      pageMode <= 1'b0;
      pageOk   <= 1'b0;
      unlocked <= 1'b0;
    end else if (!progOn) begin
      byteIdx  <= '0;
      opReg    <= '0;
      b1Reg    <= '0;
      loReg    <= '0;
      pageOff  <= '0;
      pageMode <= 1'b0;
      pageOk   <= 1'b0;
      unlocked <= 1'b0;
    end else if (byteDone) begin
      if (pageMode) begin
        pageOff <= pageOff + 8'd1;
        if (&pageOff) pageMode <= 1'b0;
      end else begin
        case (byteIdx)
          2'd0: begin
            opReg   <= byteVal;
            byteIdx <= 2'd1;
          end
          2'd1: begin
            b1Reg <= byteVal;
            if (opReg == PAGE_OP) begin
              pageMode <= 1'b1;
              pageOk   <= unlocked && !busy;
              pageOff  <= '0;
              byteIdx  <= 2'd0;
            end else begin
              byteIdx <= 2'd2;
            end
          end
          2'd2: begin
            loReg   <= byteVal;
            byteIdx <= 2'd3;
          end
          2'd3: begin
            byteIdx <= 2'd0;
            if (opReg == ENABLE_OP && b1Reg == ENABLE_KEY) unlocked <= 1'b1;
          end
        endcase
      end
    end
  end

  always_comb begin
    strb = '0;
    if (byteDone) begin
      if (pageMode) begin
        strb.byteWr = pageOk;
      end else begin
        case (byteIdx)
          2'd2: strb.readLoad = unlocked && (opReg == READ_OP);
          2'd3: begin
            strb.readEnd = 1'b1;
            if (unlocked && !busy) begin
              strb.eraseGo = (opReg == ERASE_OP) && (b1Reg == ERASE_SUB);
              strb.byteWr  = (opReg == WRITE_OP);
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [15:0] fullAddr;
  always_comb begin
    if (pageMode)             fullAddr = {b1Reg, pageOff};
    else if (byteIdx == 2'd2) fullAddr = {b1Reg, byteVal};
    else                      fullAddr = {b1Reg, loReg};
  end
  assign cmdAddr = ADDR_W'(fullAddr);
  assign cmdData = byteVal;

  // R2: no memory action while locked
  p_locked_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteWr || strb.eraseGo || strb.readLoad) |-> unlocked);
  // R8: erase and single-byte writes never start while busy
  p_no_erase_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseGo |-> !busy);
  p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteWr && !pageMode) |-> !busy);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.byteWr, strb.eraseGo, strb.readLoad}));
  // R11: leaving programming mode relocks
  p_relock_r11: assert property (@(posedge clk) disable iff (!rstN)
    !progOn |=> !unlocked);
endmodule

// File: rtl/isp_target.sv
module isp_target #(
  parameter int         ADDR_W       = 10,
  parameter int         WRITE_CYCLES = 16000,
  parameter logic [7:0] ENABLE_OP    = 8'hAC,
  parameter logic [7:0] ENABLE_KEY   = 8'h53,
  parameter logic [7:0] ERASE_OP     = 8'hAC,
  parameter logic [7:0] ERASE_SUB    = 8'h80,
  parameter logic [7:0] WRITE_OP     = 8'h40,
  parameter logic [7:0] READ_OP      = 8'h20,
  parameter logic [7:0] PAGE_OP      = 8'h50
) (
  input  logic clk,
  input  logic rstN,
  input  logic progEn,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  import isp_pkg::*;

  ispStrobes_t       strb;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;
  logic              progOn, byteDone, busy;
  logic [7:0]        byteVal;

  isp_control #(
    .ADDR_W(ADDR_W), .ENABLE_OP(ENABLE_OP), .ENABLE_KEY(ENABLE_KEY),
    .ERASE_OP(ERASE_OP), .ERASE_SUB(ERASE_SUB), .WRITE_OP(WRITE_OP),
    .READ_OP(READ_OP), .PAGE_OP(PAGE_OP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .progOn(progOn), .byteDone(byteDone),
    .byteVal(byteVal), .busy(busy), .strb(strb), .cmdAddr(cmdAddr),
    .cmdData(cmdData)
  );

  isp_datapath #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) uPath (
    .clk(clk), .rstN(rstN), .progEn(progEn), .sck(sck), .mosi(mosi),
    .strb(strb), .cmdAddr(cmdAddr), .cmdData(cmdData), .progOn(progOn),
    .byteDone(byteDone), .byteVal(byteVal), .busy(busy), .miso(miso)
  );
endmodule

// File: tb/isp_target_test.sv
module isp_target_test;
  localparam int WC   = 2000;
  localparam int HALF = 16;
  localparam logic [7:0] OP_EN = 8'hAC, OP_ER = 8'hAC, OP_WR = 8'h40,
                         OP_RD = 8'h20, OP_PG = 8'h50;

  logic clk = 1'b0, rstN = 1'b0, progEn = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso;
  always #5 clk = ~clk;

  isp_target #(.ADDR_W(10), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .progEn(progEn), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // reference model
  logic [7:0] refMem [0:1023];
  bit     refUnlocked = 1'b0;
  longint cyc = 0, lastWrCyc = -100000, eraseEnd = 0;
  int     lastA = -1;
  int     total = 0, bad = 0;
  bit     finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit refBusy();
    return ((cyc - lastWrCyc) < WC) || (cyc < eraseEnd);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5: mosi flips while sck is high, so only the rising-edge capture sees the sent bit
  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      idle(HALF);
      rx[i] = miso;
      sck = 1'b1;
      idle(HALF / 2);
      mosi = ~tx[i];
      idle(HALF - HALF / 2);
      sck = 1'b0;
    end
  endtask

  task automatic doCmd(input string req, input logic [7:0] b0, b1, b2, b3);
    logic [7:0] r0, r1, r2, r3, exp;
    int a;
    a = ((int'(b1) << 8) | int'(b2)) & 1023;
    exp = 8'h00;
    if (refUnlocked && b0 == OP_RD) begin
      exp = refMem[a];
      if ((cyc + 800 - lastWrCyc) < WC && a == lastA) exp = exp ^ 8'h80;
    end
    xferByte(b0, r0);
    xferByte(b1, r1);
    xferByte(b2, r2);
    xferByte(b3, r3);
    check("R6 idle miso", r0 | r1 | r2, 8'h00);
    check(req, r3, exp);
    if (b0 == OP_EN && b1 == 8'h53) refUnlocked = 1'b1;
    else if (refUnlocked && !refBusy()) begin
      if (b0 == OP_ER && b1 == 8'h80) begin
        for (int i = 0; i < 1024; i++) refMem[i] = 8'hFF;
        eraseEnd = cyc + 1100;
      end else if (b0 == OP_WR) begin
        refMem[a] = refMem[a] & b3;
        lastA = a;
        lastWrCyc = cyc;
      end
    end
  endtask

  task automatic doPage(input logic [7:0] pg, input logic [7:0] seed);
    logic [7:0] rx;
    bit ok;
    ok = refUnlocked && !refBusy();
    xferByte(OP_PG, rx);
    xferByte(pg, rx);
    for (int off = 0; off < 256; off++) begin
      xferByte(8'(off) ^ seed, rx);
      if (ok) begin
        refMem[((int'(pg) << 8) | off) & 1023] &= (8'(off) ^ seed);
        lastA = ((int'(pg) << 8) | off) & 1023;
      end
    end
    if (ok) lastWrCyc = cyc;
  endtask

  task automatic setProg(input logic v);
    progEn = v;
    if (!v) refUnlocked = 1'b0;
    idle(20);
  endtask

  initial begin
    logic [7:0] rx;
    idle(5);
    rstN = 1'b1;
    idle(5);
    check("R1 reset miso", {7'b0, miso}, 8'h00);
    sck = 1'b1; idle(HALF); sck = 1'b0; idle(HALF);   // R1: ignored while off
    setProg(1'b1);

    doCmd("R2 locked read", OP_RD, 8'h00, 8'h05, 8'h00);
    doCmd("R2 unlock", OP_EN, 8'h53, 8'h00, 8'h00);
    doCmd("R3 erase", OP_ER, 8'h80, 8'h00, 8'h00);
    idle(1300);
    doCmd("R3 read low", OP_RD, 8'h00, 8'h00, 8'h00);
    doCmd("R5 read top", OP_RD, 8'h03, 8'hFF, 8'h00);
    doCmd("R3 read mid", OP_RD, 8'h01, 8'h55, 8'h00);

    doCmd("R7 write", OP_WR, 8'h00, 8'h12, 8'h5A);
    doCmd("R9 polled read", OP_RD, 8'h00, 8'h12, 8'h00);
    doCmd("R9 other addr", OP_RD, 8'h00, 8'h13, 8'h00);
    idle(2300);
    doCmd("R7 settled read", OP_RD, 8'h00, 8'h12, 8'h00);

    doCmd("R8 write", OP_WR, 8'h00, 8'h40, 8'h77);
    doCmd("R8 busy write", OP_WR, 8'h00, 8'h35, 8'h22);
    idle(2300);
    doCmd("R8 dropped write", OP_RD, 8'h00, 8'h35, 8'h00);
    doCmd("R8 write2", OP_WR, 8'h00, 8'h41, 8'h66);
    doCmd("R8 busy erase", OP_ER, 8'h80, 8'h00, 8'h00);
    idle(2300);
    doCmd("R8 dropped erase", OP_RD, 8'h00, 8'h41, 8'h00);

    doCmd("R4 rewrite", OP_WR, 8'h00, 8'h12, 8'hF0);
    idle(2300);
    doCmd("R4 and result", OP_RD, 8'h00, 8'h12, 8'h00);
    doCmd("R12 unknown op", 8'h99, 8'h00, 8'h12, 8'h00);
    doCmd("R12 unchanged", OP_RD, 8'h00, 8'h12, 8'h00);

    // R11: partial instruction and unlock lost when progEn drops
    xferByte(OP_RD, rx);
    xferByte(8'h00, rx);
    setProg(1'b0);
    check("R1 miso off", {7'b0, miso}, 8'h00);
    setProg(1'b1);
    doCmd("R11 relocked read", OP_RD, 8'h00, 8'h12, 8'h00);
    doCmd("R11 locked write", OP_WR, 8'h00, 8'h12, 8'h00);
    doCmd("R11 unlock", OP_EN, 8'h53, 8'h00, 8'h00);
    doCmd("R11 content kept", OP_RD, 8'h00, 8'h12, 8'h00);

    doPage(8'h01, 8'h3C);
    doCmd("R9 page poll", OP_RD, 8'h01, 8'hFF, 8'h00);
    idle(2300);
    doCmd("R10 page first", OP_RD, 8'h01, 8'h00, 8'h00);
    doCmd("R10 page mid", OP_RD, 8'h01, 8'h7F, 8'h00);
    doCmd("R10 page last", OP_RD, 8'h01, 8'hFF, 8'h00);
    doCmd("R10 below page", OP_RD, 8'h00, 8'hFF, 8'h00);
    doCmd("R10 above page", OP_RD, 8'h02, 8'h00, 8'h00);

    doCmd("R3 erase again", OP_ER, 8'h80, 8'h00, 8'h00);
    idle(1300);
    doCmd("R3 refilled", OP_RD, 8'h00, 8'h12, 8'h00);
    doCmd("R3 page refilled", OP_RD, 8'h01, 8'h7F, 8'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule